// File: doc/BRIEF.md
# Board Identification String Decoder

This block fetches a board identification number from a word-addressed non-volatile store and turns it into a stream of ASCII characters. A one-cycle `start` pulse begins the work. The block first reads two header words from fixed addresses. If the first header word differs from a guard value, both header words hold packed hex digits. These are expanded into a ten-character text that has a dash and a zero digit inserted. If the first header word equals the guard value, the second one is a pointer to a length-prefixed string. That string is stored two characters per word, with the high byte first.

Memory reads use a simple request/acknowledge port. `mem_req` and `mem_addr` stay steady until the store returns `mem_ack`, which comes with the data and a fault flag. Characters leave on a valid/ready stream. The final character carries `out_last`, and no terminator byte is sent. A caller-supplied size limit is compared against the room the string needs, terminator included. When the string would not fit, nothing is emitted and an error is reported. `done` pulses for one cycle with a result code when the work ends.

Top module: `board_id_decoder`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `mem_req` and `out_valid` are 0 and `err_code` is 0.
- R2: A run reads the word at `HDR0_ADDR`, then the word at `HDR1_ADDR`. A first word different from `GUARD` selects the packed format, and equal to `GUARD` selects the pointer format.
- R3: In the packed format, with header words A and B, the ten characters are: the four nibbles of A most significant first, then B[15:12] and B[11:8], then '-' (0x2D), then '0' (0x30), then B[7:4] and B[3:0]. Each nibble 0-9 becomes 0x30-0x39, and each nibble 10-15 becomes 0x41-0x46.
- R4: In the packed format, a size limit below 11 ends the run with `err_code` 3 (no room) and no characters.
- R5: In the pointer format the length word is read at the address held in the second header word. A length of 0x0000 or 0xFFFF ends the run with `err_code` 2 (bad length) and no characters.
- R6: In the pointer format, a size limit below 2*length-1 ends the run with `err_code` 3 and no characters.
- R7: In the pointer format, length-1 words are read from consecutive addresses that start one past the length word. Each word yields its high byte, then its low byte. A length of 1 ends the run with `err_code` 0 and no characters.
- R8: A read acknowledged with `mem_err` high ends the run at once with `err_code` 1. No further read is made and no further character is emitted; characters already sent stay sent.
- R9: `out_last` is high only on the final character of a successful run. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady.
- R10: `done` is a one-cycle pulse at the end of each run, and `err_code` is valid with it (0 ok, 1 read fault, 2 bad length, 3 no room). A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| size_limit | input | 16 | Room available, in characters, terminator counted; captured at start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | Result of the last run |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | AW | Word address of the read |
| mem_ack | input | 1 | Read complete this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_err | input | 1 | Read failed, valid with mem_ack |
| out_valid | output | 1 | Character available |
| out_data | output | 8 | ASCII character |
| out_last | output | 1 | Final character of the run |
| out_ready | input | 1 | Consumer accepts the character |

## Verification
The hardest case to reach is a read fault partway through a pointer-format string. Part of the string has already left on the stream when the fault arrives, so the run must stop cleanly at a word boundary. The bench sets a fault on a chosen string-word address inside the store model and predicts the partial byte list. The random runs add acknowledge latency and consumer stalls, which push the fault and the size-limit edges into varying stream states.

// File: rtl/board_id_decoder.sv
module board_id_decoder #(
  parameter int          AW        = 16,
  parameter logic [15:0] GUARD     = 16'hFAFA,
  parameter logic [15:0] HDR0_ADDR = 16'h0008,
  parameter logic [15:0] HDR1_ADDR = 16'h0009,
  parameter int          LEG_CHARS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   size_limit,
  output logic          busy,
  output logic          done,
  output logic [1:0]    err_code,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_err,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  input  logic          out_ready
);
  localparam logic [15:0] LEG_ROOM = 16'(LEG_CHARS + 1);
  localparam int          IW       = $clog2(LEG_CHARS);
  localparam logic [1:0]  E_OK = 2'd0, E_RD = 2'd1, E_LEN = 2'd2, E_ROOM = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR0, S_HDR1, S_LEN, S_WORD, S_HI, S_LO, S_LEG, S_FIN
  } st_t;

  st_t           st;
  logic [15:0]   hdr0, hdr1, word, remain, lim;
  logic [AW-1:0] addr;
  logic [IW-1:0] idx;
  logic [3:0]    nib;
  logic [7:0]    leg_ch;
  logic          rd_ok, rd_bad;
  logic [17:0]   need_x2, have_p1;

  function automatic logic [7:0] to_hex(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign mem_req   = (st == S_HDR0) || (st == S_HDR1) || (st == S_LEN) || (st == S_WORD);
  assign mem_addr  = addr;
  assign rd_ok     = mem_req && mem_ack && !mem_err;
  assign rd_bad    = mem_req && mem_ack && mem_err;
  assign need_x2   = {1'b0, mem_rdata, 1'b0};
  assign have_p1   = {2'b00, lim} + 18'd1;

  always_comb begin
    case (idx)
      IW'(0):  nib = hdr0[15:12];
      IW'(1):  nib = hdr0[11:8];
      IW'(2):  nib = hdr0[7:4];
      IW'(3):  nib = hdr0[3:0];
      IW'(4):  nib = hdr1[15:12];
      IW'(5):  nib = hdr1[11:8];
      IW'(8):  nib = hdr1[7:4];
      IW'(9):  nib = hdr1[3:0];
      default: nib = 4'h0;
    endcase
  end

  assign leg_ch    = (idx == IW'(6)) ? 8'h2D : to_hex(nib);
  assign out_valid = (st == S_HI) || (st == S_LO) || (st == S_LEG);
  assign out_data  = (st == S_HI) ? word[15:8] : (st == S_LO) ? word[7:0] : leg_ch;
  assign out_last  = ((st == S_LO) && (remain == 16'd1)) ||
                     ((st == S_LEG) && (idx == IW'(LEG_CHARS - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      hdr0     <= '0;
      hdr1     <= '0;
      word     <= '0;
      remain   <= '0;
      lim      <= '0;
      addr     <= '0;
      idx      <= '0;
      err_code <= E_OK;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_HDR0;
          addr     <= AW'(HDR0_ADDR);
          lim      <= size_limit;
          err_code <= E_OK;
        end
        S_HDR0: if (rd_bad) begin
          err_code <= E_RD; st <= S_FIN;
        end else if (rd_ok) begin
          hdr0 <= mem_rdata;
          addr <= AW'(HDR1_ADDR);
          st   <= S_HDR1;
        end
        S_HDR1: if (rd_bad) begin
          err_code <= E_RD; st <= S_FIN;
        end else if (rd_ok) begin
          hdr1 <= mem_rdata;
          idx  <= '0;
          if (hdr0 != GUARD) begin
            if (lim < LEG_ROOM) begin
              err_code <= E_ROOM; st <= S_FIN;
            end else st <= S_LEG;
          end else begin
            addr <= mem_rdata[AW-1:0];
            st   <= S_LEN;
          end
        end
        S_LEN: if (rd_bad) begin
          err_code <= E_RD; st <= S_FIN;
        end else if (rd_ok) begin
          if (mem_rdata == 16'h0000 || mem_rdata == 16'hFFFF) begin
            err_code <= E_LEN; st <= S_FIN;
          end else if (have_p1 < need_x2) begin
            err_code <= E_ROOM; st <= S_FIN;
          end else if (mem_rdata == 16'd1) begin
            st <= S_FIN;
          end else begin
            remain <= mem_rdata - 16'd1;
            addr   <= addr + AW'(1);
            st     <= S_WORD;
          end
        end
        S_WORD: if (rd_bad) begin
          err_code <= E_RD; st <= S_FIN;
        end else if (rd_ok) begin
          word <= mem_rdata;
          st   <= S_HI;
        end
        S_HI: if (out_ready) st <= S_LO;
        S_LO: if (out_ready) begin
          remain <= remain - 16'd1;
          addr   <= addr + AW'(1);
          st     <= (remain == 16'd1) ? S_FIN : S_WORD;
        end
        S_LEG: if (out_ready) begin
          idx <= idx + IW'(1);
          if (idx == IW'(LEG_CHARS - 1)) st <= S_FIN;
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/board_id_decoder_chk.sv
module board_id_decoder_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [1:0]    err_code,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          mem_err,
  input logic          out_valid,
  input logic [7:0]    out_data,
  input logic          out_last,
  input logic          out_ready
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !out_valid && !done)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R2
  AST_NO_READ_WHILE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_req); // R7
  AST_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> (done && err_code == 2'd1 && !mem_req && !out_valid)); // R8
  AST_OUT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (done && err_code == 2'd0)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

bind board_id_decoder board_id_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err_code(err_code),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
  .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
);

// File: tb/board_id_decoder_bench.sv
`timescale 1ns/1ps
module board_id_decoder_bench;
  localparam logic [15:0] GUARD = 16'hFAFA;
  localparam logic [15:0] A0 = 16'h0008, A1 = 16'h0009;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [15:0] size_limit = 0;
  logic        busy, done, mem_req, mem_ack = 0, mem_err = 0;
  logic [1:0]  err_code;
  logic [15:0] mem_addr, mem_rdata = 0;
  logic        out_valid, out_last, out_ready = 0;
  logic [7:0]  out_data;

  board_id_decoder u_board_id_decoder (
    .clk(clk), .rst_n(rst_n), .start(start), .size_limit(size_limit),
    .busy(busy), .done(done), .err_code(err_code),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_err(mem_err),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  always #10 clk = ~clk;

  logic [15:0] mem [256];
  bit          fault_en = 0, stall = 0;
  logic [15:0] fault_addr = 0;
  int checks = 0, errors = 0;
  int gn = 0, dones = 0;
  logic [7:0] got [64];
  bit         glast [64];
  logic [1:0] gerr;
  logic [7:0] expb [64];
  int         exp_n;
  logic [1:0] exp_err;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, expv);
    end
  endtask

  // store responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && ($urandom % 3 != 0)) begin
        mem_ack = 1; mem_rdata = mem[mem_addr[7:0]];
        mem_err = fault_en && (mem_addr == fault_addr);
      end else begin
        mem_ack = 0; mem_rdata = 16'($urandom); mem_err = 0;
      end
    end
  end

  // stream consumer
  initial begin
    forever begin
      @(negedge clk);
      out_ready = stall ? 1'($urandom % 2) : 1'b1;
      if (out_valid && out_ready && gn < 64) begin
        got[gn] = out_data; glast[gn] = out_last; gn++;
      end
      if (done) begin dones++; gerr = err_code; end
    end
  end

  function automatic logic [7:0] hx(input logic [3:0] n);
    if (n > 4'd9) return "A" + 8'(n - 4'd10);
    return "0" + 8'(n);
  endfunction

  function automatic bit flt(input logic [15:0] a);
    return fault_en && a == fault_addr;
  endfunction

  task automatic model();
    logic [15:0] w0, w1, len, a;
    exp_n = 0; exp_err = 0;
    if (flt(A0)) begin exp_err = 1; return; end
    w0 = mem[A0[7:0]];
    if (flt(A1)) begin exp_err = 1; return; end
    w1 = mem[A1[7:0]];
    if (w0 != GUARD) begin
      if (size_limit < 11) begin exp_err = 3; return; end
      expb[0] = hx(w0[15:12]); expb[1] = hx(w0[11:8]); expb[2] = hx(w0[7:4]);
      expb[3] = hx(w0[3:0]);   expb[4] = hx(w1[15:12]); expb[5] = hx(w1[11:8]);
      expb[6] = "-"; expb[7] = "0"; expb[8] = hx(w1[7:4]); expb[9] = hx(w1[3:0]);
      exp_n = 10; return;
    end
    if (flt(w1)) begin exp_err = 1; return; end
    len = mem[w1[7:0]];
    if (len == 0 || len == 16'hFFFF) begin exp_err = 2; return; end
    if (int'(size_limit) < 2 * int'(len) - 1) begin exp_err = 3; return; end
    for (int k = 1; k < int'(len); k++) begin
      a = w1 + 16'(k);
      if (flt(a)) begin exp_err = 1; return; end
      expb[exp_n] = mem[a[7:0]][15:8]; expb[exp_n+1] = mem[a[7:0]][7:0];
      exp_n += 2;
    end
  endtask

  task automatic run(input string tag, input bit restart);
    int cyc = 0;
    model();
    gn = 0; dones = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (dones == 0 && cyc < 3000) begin
      @(negedge clk); cyc++;
      start = (restart && cyc == 4);
    end
    start = 0;
    repeat (4) @(negedge clk);
    chk(cyc < 3000, {tag, " watchdog"}, cyc, 3000);
    chk(dones == 1, {tag, " R10 single done"}, dones, 1);
    chk(gerr == exp_err, {tag, " R10 err_code"}, gerr, exp_err);
    chk(gn == exp_n, {tag, " char count"}, gn, exp_n);
    for (int i = 0; i < exp_n && i < gn; i++) begin
      chk(got[i] == expb[i], {tag, " R3/R7 char"}, got[i], expb[i]);
      chk(glast[i] == (exp_err == 0 && i == exp_n - 1), {tag, " R9 last flag"}, glast[i],
          (exp_err == 0 && i == exp_n - 1));
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
  endtask

  task automatic set_ptr(input logic [15:0] p, input logic [15:0] len);
    mem[A0[7:0]] = GUARD; mem[A1[7:0]] = p; mem[p[7:0]] = len;
  endtask

  initial begin
    void'($urandom(32'd2024));
    fill();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !out_valid, "R1 idle after reset", busy, 0);
    chk(err_code == 0, "R1 err_code after reset", err_code, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 packed format, directed
    mem[A0[7:0]] = 16'h1A2F; mem[A1[7:0]] = 16'hB3C4; size_limit = 11;
    run("R3 packed", 0);
    chk(exp_n == 10 && expb[9] == "4", "R3 model sanity", exp_n, 10);
    size_limit = 10; run("R4 packed limit 10", 0);
    // R5 bad lengths
    size_limit = 100;
    set_ptr(16'h0030, 16'h0000); run("R5 len 0", 0);
    set_ptr(16'h0030, 16'hFFFF); run("R5 len FFFF", 0);
    // R6 room edge
    set_ptr(16'h0040, 16'd5); size_limit = 9; run("R6 exact room", 0);
    size_limit = 8; run("R6 one short", 0);
    // R7 length 1
    set_ptr(16'h0050, 16'd1); size_limit = 1; run("R7 len 1", 0);
    // R8 faults
    size_limit = 100;
    fault_en = 1; fault_addr = A0; run("R8 fault hdr0", 0);
    set_ptr(16'h0060, 16'd6); fault_addr = 16'h0063; stall = 1; run("R8 fault mid string", 0);
    fault_en = 0;
    // R10 restart ignored
    set_ptr(16'h0070, 16'd4); run("R10 start while busy", 1);

    for (int t = 0; t < 40; t++) begin
      fill();
      stall = 1'($urandom % 2);
      if ($urandom % 2) begin
        mem[A0[7:0]] = 16'($urandom);
        if (mem[A0[7:0]] == GUARD) mem[A0[7:0]] = 16'h0;
        size_limit = 16'(8 + $urandom % 6);
      end else begin
        set_ptr(16'(16'h20 + $urandom % 96), 16'($urandom % 20));
        size_limit = 16'($urandom % 42);
      end
      fault_en = ($urandom % 5 == 0);
      fault_addr = mem[A1[7:0]] + 16'($urandom % 4);
      run("R2 random mix", 0);
    end
    fault_en = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule